// File: doc/BRIEF.md
# Offset-QPSK Transition Bit Decoder

This block sits behind the slicers of an offset-QPSK receiver. It takes the two hard-decided quadrature levels and a symbol-rate clock, and it produces a single serial bit stream with a one-cycle strobe for each bit. The transmitter encodes data in the changes of each quadrature level, so the decoder compares every new sample of a level with the previous sample of that same level. A change gives a 1 and no change gives a 0. Because of this, the decoder does not need to resolve the carrier phase: a channel that arrives inverted decodes to the same bits.

The in-phase level is sampled on the rising edge of the symbol clock. The quadrature level is sampled on the falling edge of the symbol clock, half a symbol later, which matches the offset between the two channels. The symbol clock and both levels come from another timing domain. They pass through a synchronizer chain of equal depth, so a level and a clock edge that arrive in the same cycle stay aligned with each other. The two per-lane bit streams are interleaved onto one output, and the in-phase bit always goes first. The first comparison each lane makes after reset is made against the reset value rather than a real earlier sample, so that bit is thrown away.

Top module: `oqd_diff_decoder`

## Requirements
- R1: While `rst` is high, and after reset until the first decoded bit, `ser_stb` and `ser_data` are both 0.
- R2: The in-phase level is sampled when the synchronized `sym_clk` goes from 0 to 1. The quadrature level is sampled when the synchronized `sym_clk` goes from 1 to 0. At most one lane produces a bit in any cycle.
- R3: A decoded bit is 1 when the sampled level differs from the previous sample of the same lane, and 0 when it is equal.
- R4: Inverting the levels of both channels, or of either one, produces exactly the same output bit stream.
- R5: After reset, the first sample of each lane produces no output bit, so the first strobe carries the in-phase lane's second sample.
- R6: Output bits alternate strictly between the in-phase and quadrature lanes, beginning with the in-phase lane.
- R7: `ser_stb` is high for exactly one cycle per bit. `ser_data` changes only in a cycle where `ser_stb` is high, and it holds its value otherwise.
- R8: When a `sym_clk` edge is first sampled at clock edge k, its bit appears with `ser_stb` high in the cycle that follows clock edge k+SYNC_STAGES+1.
- R9: The level used for a lane is the value present at the inputs in the same `clk` cycle as the `sym_clk` edge, even if the level changes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than twice the symbol rate |
| rst | input | 1 | Synchronous active-high reset |
| sym_clk | input | 1 | Recovered symbol-rate clock, as a level (asynchronous) |
| lvl_i | input | 1 | Sliced in-phase level (asynchronous) |
| lvl_q | input | 1 | Sliced quadrature level (asynchronous) |
| ser_data | output | 1 | Decoded serial bit, valid when `ser_stb` is high |
| ser_stb | output | 1 | One-cycle strobe for each decoded bit |

## Verification
The bench runs a behavioural model of the interleaved stream through a fixed-latency queue and compares both outputs against it on every clock.

It aims at the following corner cases, each with the fault it would expose:
- A lane that alone toggles on every symbol. A decoder that swapped the sampling edges, or started with the quadrature lane, would produce the interleave 0,1 instead of 1,0.
- A pseudo-random stream replayed with both levels inverted. A decoder that kept any dependence on absolute polarity, or emitted the first comparison against the reset value, would output a different stream.
- Levels that change in the same cycle as the clock edge, and a reset applied in the middle of a stream. These expose a synchronizer depth that is unequal between clock and data, and state that is not cleared by reset.

// File: rtl/oqd_pkg.sv
package oqd_pkg;

    localparam int unsigned NUM_LANES = 2;

    typedef enum logic {
        LANE_I = 1'b0,
        LANE_Q = 1'b1
    } lane_e;

    typedef struct packed {
        logic vld;
        logic dbit;
    } lane_bit_t;

    function automatic logic level_changed(input logic now_l, input logic was_l);
        return now_l ^ was_l;
    endfunction

endpackage

// File: rtl/oqd_sync.sv
module oqd_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stg [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < STAGES; k++) stg[k] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/oqd_phase.sv
module oqd_phase
    import oqd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_s,
    output logic [NUM_LANES-1:0] lane_en
);

    logic sym_prev;

    always_ff @(posedge clk) begin
        if (rst) sym_prev <= 1'b0;
        else     sym_prev <= sym_s;
    end

    always_comb begin
        lane_en = '0;
        lane_en[int'(LANE_I)] = sym_s & ~sym_prev;
        lane_en[int'(LANE_Q)] = ~sym_s & sym_prev;
    end

endmodule

// File: rtl/oqd_lane.sv
module oqd_lane
    import oqd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      lvl,
    output lane_bit_t res
);

    logic smp;
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp    <= 1'b0;
            primed <= 1'b0;
            res    <= '0;
        end else if (en) begin
            smp      <= lvl;
            primed   <= 1'b1;
            res.dbit <= level_changed(lvl, smp);
            res.vld  <= primed;
        end else begin
            res.vld  <= 1'b0;
        end
    end

    // R8: a lane bit is only ever the result of the clock edge one cycle earlier
    assert_strobe_follows_edge_R8: assert property (@(posedge clk) disable iff (rst)
        res.vld |-> $past(en));

endmodule

// File: rtl/oqd_merge.sv
module oqd_merge
    import oqd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_bit_t lanes [NUM_LANES],
    output logic      ser_data,
    output logic      ser_stb
);

    lane_bit_t li, lq;
    logic      expect_q;

    assign li = lanes[int'(LANE_I)];
    assign lq = lanes[int'(LANE_Q)];

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_data <= 1'b0;
            ser_stb  <= 1'b0;
            expect_q <= 1'b0;
        end else begin
            ser_stb <= li.vld | lq.vld;
            if (li.vld) begin
                ser_data <= li.dbit;
                expect_q <= 1'b1;
            end else if (lq.vld) begin
                ser_data <= lq.dbit;
                expect_q <= 1'b0;
            end
        end
    end

    assert_one_lane_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({li.vld, lq.vld}));

    assert_i_turn_R6: assert property (@(posedge clk) disable iff (rst)
        li.vld |-> !expect_q);

    assert_q_turn_R6: assert property (@(posedge clk) disable iff (rst)
        lq.vld |-> expect_q);

endmodule

// File: rtl/oqd_diff_decoder.sv
module oqd_diff_decoder
    import oqd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_clk,
    input  logic lvl_i,
    input  logic lvl_q,
    output logic ser_data,
    output logic ser_stb
);

    localparam int unsigned SYNC_W = NUM_LANES + 1;
    localparam int unsigned CLK_IX = NUM_LANES;

    logic [SYNC_W-1:0]    raw_in;
    logic [SYNC_W-1:0]    syn_in;
    logic [NUM_LANES-1:0] lane_en;
    lane_bit_t            lanes [NUM_LANES];

    always_comb begin
        raw_in = '0;
        raw_in[int'(LANE_I)] = lvl_i;
        raw_in[int'(LANE_Q)] = lvl_q;
        raw_in[CLK_IX]       = sym_clk;
    end

    oqd_sync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    oqd_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .sym_s   (syn_in[CLK_IX]),
        .lane_en (lane_en)
    );

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            oqd_lane u_lane (
                .clk (clk),
                .rst (rst),
                .en  (lane_en[g]),
                .lvl (syn_in[g]),
                .res (lanes[g])
            );
        end
    endgenerate

    oqd_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .lanes    (lanes),
        .ser_data (ser_data),
        .ser_stb  (ser_stb)
    );

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ser_stb |-> $stable(ser_data));

endmodule

// File: tb/sim_oqd_diff_decoder.sv
`timescale 1ns/1ps
module sim_oqd_diff_decoder;

    localparam int N    = 2;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_clk = 1'b0;
    logic lvl_i = 1'b0;
    logic lvl_q = 1'b0;
    logic ser_data, ser_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    oqd_diff_decoder #(.SYNC_STAGES(N)) u0 (
        .clk(clk), .rst(rst), .sym_clk(sym_clk), .lvl_i(lvl_i), .lvl_q(lvl_q),
        .ser_data(ser_data), .ser_stb(ser_stb)
    );

    // behavioural reference: transitions per lane, delayed by a fixed latency
    bit [1:0] expq [$];
    bit m_pc, m_pi, m_pq, m_ri, m_rq, m_last;
    bit got [$];

    always @(posedge clk) begin
        bit stb, dat;
        if (rst) begin
            m_pc = 0; m_pi = 0; m_pq = 0; m_ri = 0; m_rq = 0; m_last = 0;
            expq.delete();
            for (int k = 0; k < N + 2; k++) expq.push_back(2'b00);
        end else begin
            stb = 0; dat = m_last;
            if (sym_clk && !m_pc) begin
                if (m_ri) begin stb = 1; dat = lvl_i ^ m_pi; end
                m_pi = lvl_i; m_ri = 1;
            end else if (!sym_clk && m_pc) begin
                if (m_rq) begin stb = 1; dat = lvl_q ^ m_pq; end
                m_pq = lvl_q; m_rq = 1;
            end
            m_pc = sym_clk;
            m_last = dat;
            expq.push_back({stb, dat});
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit [1:0] e;
        if (expq.size() > 0 && !done) begin
            e = expq.pop_front();
            check({ser_stb, ser_data} == e, "R7/R8/R9 per-cycle model",
                  int'({ser_stb, ser_data}), int'(e));
            if (ser_stb) got.push_back(ser_data);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic drive_half(input bit s, input bit i, input bit q);
        @(negedge clk);
        sym_clk = s; lvl_i = i; lvl_q = q;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; sym_clk = 0; lvl_i = 0; lvl_q = 0;
        repeat (3) @(negedge clk);
        check(ser_stb == 0 && ser_data == 0, "R1 in reset", int'({ser_stb, ser_data}), 0);
        rst = 0;
        repeat (4) @(negedge clk);
        got.delete();
    endtask

    task automatic drain();
        drive_half(0, lvl_i, lvl_q);
        repeat (N + 6) @(negedge clk);
    endtask

    // normal: I changes with the low half, Q changes with the high half
    task automatic run_seq(input bit ia[], input bit qa[]);
        for (int k = 0; k < ia.size(); k++) begin
            drive_half(0, ia[k], lvl_q);
            drive_half(1, ia[k], qa[k]);
        end
        drain();
    endtask

    task automatic check_stream(input bit exp[$], input string req);
        check(got.size() == exp.size(), req, got.size(), exp.size());
        for (int k = 0; k < exp.size() && k < got.size(); k++)
            check(got[k] == exp[k], req, int'(got[k]), int'(exp[k]));
    endtask

    initial begin
        bit ia[], qa[], exp[$], saved[$];
        int lf;

        // R1: outputs quiet through reset and idle
        do_reset();
        check(ser_stb == 0 && ser_data == 0, "R1 after reset", int'({ser_stb, ser_data}), 0);

        // R3/R5/R6: only I toggles -> 1,0,1,0 starting with I
        ia = new[8]; qa = new[8];
        for (int k = 0; k < 8; k++) begin ia[k] = (k % 2 == 0); qa[k] = 1; end
        run_seq(ia, qa);
        exp.delete();
        for (int k = 0; k < 7; k++) begin exp.push_back(1); exp.push_back(0); end
        check_stream(exp, "R3 R5 R6 I-toggle");

        // R2/R6: only Q toggles -> 0,1,0,1
        do_reset();
        for (int k = 0; k < 8; k++) begin ia[k] = 0; qa[k] = (k % 2 == 1); end
        run_seq(ia, qa);
        exp.delete();
        for (int k = 0; k < 7; k++) begin exp.push_back(0); exp.push_back(1); end
        check_stream(exp, "R2 R6 Q-toggle");

        // R3: pseudo-random stream against direct transition rule
        do_reset();
        ia = new[40]; qa = new[40]; lf = 32'h1ACE5;
        for (int k = 0; k < 40; k++) begin
            lf = (lf >> 1) ^ ((lf & 1) != 0 ? 32'hB400 : 0);
            ia[k] = lf[0]; qa[k] = lf[3];
        end
        run_seq(ia, qa);
        exp.delete();
        for (int k = 1; k < 40; k++) begin
            exp.push_back(ia[k] ^ ia[k-1]);
            exp.push_back(qa[k] ^ qa[k-1]);
        end
        check_stream(exp, "R3 random");
        saved = got;

        // R4: same stream with both levels inverted
        do_reset();
        for (int k = 0; k < 40; k++) begin ia[k] = !ia[k]; qa[k] = !qa[k]; end
        run_seq(ia, qa);
        check_stream(saved, "R4 inverted");

        // R4: only Q inverted
        do_reset();
        for (int k = 0; k < 40; k++) ia[k] = !ia[k];
        run_seq(ia, qa);
        check_stream(saved, "R4 Q-only inverted");

        // R9: levels change in the same cycle as the sampling edge
        do_reset();
        for (int k = 0; k < 8; k++) begin
            drive_half(0, lvl_i, 1);
            drive_half(1, (k % 2 == 0), 1);
        end
        drain();
        exp.delete();
        for (int k = 0; k < 7; k++) begin exp.push_back(1); exp.push_back(0); end
        check_stream(exp, "R9 coincident edge");

        // R1/R5: reset in the middle of a toggling stream
        for (int k = 0; k < 4; k++) begin
            drive_half(0, (k % 2 == 0), 0);
            drive_half(1, (k % 2 == 0), (k % 2 == 0));
        end
        do_reset();
        check(ser_stb == 0 && ser_data == 0, "R1 mid-run reset", int'({ser_stb, ser_data}), 0);
        drive_half(0, 1, 1);
        drive_half(1, 1, 1);
        drive_half(0, 1, 1);
        repeat (N + 6) @(negedge clk);
        check(got.size() == 0, "R5 first samples dropped", got.size(), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule